// File: doc/BRIEF.md
# Vectored Bus Interrupter

This block raises a prioritised bus interrupt for a counting module on behalf of three causes: an overflow in any counter channel, a rising edge on the external shadow-transfer strobe, and a software-owned test bit. Each cause has its own enable flag. Software raises and lowers these flags by writing one-shot set and clear masks. A separate identification word carries a fixed module number and version in its upper bits. Its lower twelve bits hold the vector, the request level and a master switch, and software writes them.

When an enabled cause is present, the master switch is on and the level is non-zero, the block drives the one bus request line that matches the programmed level. An acknowledge cycle at that level returns the 8-bit vector for one cycle. After that the request stays low until the pending condition has fully gone away. Software therefore rearms a source in three steps: it disables the source, removes the cause, then enables the source again. A pollable flag shows whether any enabled cause is pending, whatever the bus-side settings are.

Top module: `vec_interrupter`

## Requirements
- R1: `reg_rdata` is {MOD_ID[15:0], VERSION[3:0], ctl[11:0]}, where ctl bits 7:0 are the vector, bits 10:8 the level and bit 11 the master enable. A write with `reg_wr` loads only `reg_wdata[11:0]`, and bits 31:12 of the write are ignored.
- R2: Source index 0 is overflow, 1 is shadow strobe and 2 is the test bit. `en_set[k]` turns the enable of source k on and `en_clr[k]` turns it off. When both are high in the same cycle, that enable keeps its value.
- R3: The overflow cause is the OR of all `ovf_bits`. It follows the input with no storage.
- R4: A rising edge of `shd_strobe` (high now, low in the previous cycle) sets a shadow latch. `shd_clr` clears the latch. If an edge and `shd_clr` arrive in the same cycle, the latch is set.
- R5: `tst_set` sets the test bit and `tst_clr` clears it. If both arrive in the same cycle, the bit is set.
- R6: `irq_flag` is high when some source has both its cause and its enable. The master enable and the level have no effect on it.
- R7: `irq_lines[L-1]` is high, and every other line is low, exactly when `irq_flag` is set, the master enable is 1, the level L is 1..7 and no acknowledge is outstanding. Level 0 drives no line.
- R8: When `iack` is high, a request is active and `iack_lvl` equals the level, the next cycle shows `iack_valid` = 1 and `iack_data` = the vector for one cycle. At all other times both read 0. An acknowledge at another level is ignored.
- R9: After an accepted acknowledge, every request line stays low until `irq_flag` has been 0 for at least one clock edge. After that the request can rise again.
- R10: After reset, the enables, the shadow latch, the test bit and ctl are all 0. The request lines, `iack_valid` and `iack_data` are also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the identification/control word |
| reg_wdata | input | 32 | Write data, only bits 11:0 are used |
| reg_rdata | output | 32 | Identification and control word |
| en_set | input | 3 | Per-source enable set mask |
| en_clr | input | 3 | Per-source enable clear mask |
| ovf_bits | input | NUM_CH | Channel overflow bits |
| shd_strobe | input | 1 | External shadow-transfer strobe |
| shd_clr | input | 1 | Clear the shadow latch |
| tst_set | input | 1 | Set the test cause |
| tst_clr | input | 1 | Clear the test cause |
| iack | input | 1 | Acknowledge cycle strobe |
| iack_lvl | input | 3 | Level being acknowledged |
| irq_flag | output | 1 | Pending enabled condition, for polling |
| irq_lines | output | 7 | Request lines for levels 1..7, active high |
| iack_valid | output | 1 | Vector valid, one cycle after acknowledge |
| iack_data | output | 8 | Vector returned during acknowledge |

## Verification
The register state, enables, latches and acknowledge bookkeeping update on the clock edge that samples a stimulus. `reg_rdata`, `irq_flag` and `irq_lines` are combinational from that state and from `ovf_bits`, so they reflect a stimulus right after that same edge. `iack_valid` and `iack_data` are registered and appear on the edge that accepts the acknowledge. The bench drives each stimulus after a falling edge and advances its model on the next rising edge. On the falling edge that follows, it compares every output against the model, which lines up each result with the cycle it is due in.

// File: rtl/vi_pkg.sv
package vi_pkg;

  localparam int NSRC    = 3;
  localparam int SRC_OVF = 0;
  localparam int SRC_SHD = 1;
  localparam int SRC_TST = 2;
  localparam int NLVL    = 7;
  localparam int CTL_W   = 12;

  // bit order matches the word: en = 11, lvl = 10:8, vec = 7:0
  typedef struct packed {
    logic       en;
    logic [2:0] lvl;
    logic [7:0] vec;
  } irq_ctl_t;

  function automatic logic [NLVL-1:0] level_line(input logic [2:0] lvl);
    logic [NLVL-1:0] l;
    l = '0;
    if (lvl != 3'd0) l[lvl - 3'd1] = 1'b1;
    return l;
  endfunction

  function automatic logic [31:0] id_word(input logic [15:0] mod_id,
                                          input logic [3:0] ver,
                                          input irq_ctl_t ctl);
    return {mod_id, ver, ctl};
  endfunction

endpackage

// File: rtl/vi_id_reg.sv
module vi_id_reg
  import vi_pkg::*;
#(
  parameter logic [15:0] MOD_ID  = 16'h3803,
  parameter logic [3:0]  VERSION = 4'h2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] wdata,
  output irq_ctl_t    ctl,
  output logic [31:0] rdata
);

  always_ff @(posedge clk) begin
    if (!rst_n)  ctl <= '0;
    else if (wr) ctl <= irq_ctl_t'(wdata[CTL_W-1:0]);
  end

  assign rdata = id_word(MOD_ID, VERSION, ctl);

  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(ctl)); // R1

endmodule

// File: rtl/vi_sources.sv
module vi_sources
  import vi_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   en_set,
  input  logic [NSRC-1:0]   en_clr,
  input  logic [NUM_CH-1:0] ovf_bits,
  input  logic              shd_strobe,
  input  logic              shd_clr,
  input  logic              tst_set,
  input  logic              tst_clr,
  output logic [NSRC-1:0]   cond,
  output logic [NSRC-1:0]   en,
  output logic              pending
);

  logic strobe_q;
  logic shd_lat;
  logic tst_bit;
  logic shd_edge;

  assign shd_edge = shd_strobe & ~strobe_q;

  for (genvar k = 0; k < NSRC; k++) begin : g_en
    always_ff @(posedge clk) begin
      if (!rst_n)                        en[k] <= 1'b0;
      else if (en_set[k] && !en_clr[k])  en[k] <= 1'b1;
      else if (en_clr[k] && !en_set[k])  en[k] <= 1'b0;
    end

    AST_EN_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (en_set[k] && en_clr[k]) |=> $stable(en[k])); // R2
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      shd_lat  <= 1'b0;
      tst_bit  <= 1'b0;
    end else begin
      strobe_q <= shd_strobe;
      if (shd_edge)     shd_lat <= 1'b1;
      else if (shd_clr) shd_lat <= 1'b0;
      if (tst_set)      tst_bit <= 1'b1;
      else if (tst_clr) tst_bit <= 1'b0;
    end
  end

  assign cond[SRC_OVF] = |ovf_bits;
  assign cond[SRC_SHD] = shd_lat;
  assign cond[SRC_TST] = tst_bit;
  assign pending       = |(cond & en);

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (shd_lat && !shd_clr) |=> shd_lat); // R4
  AST_TEST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tst_bit && !tst_clr) |=> tst_bit); // R5

endmodule

// File: rtl/vi_bus.sv
module vi_bus
  import vi_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pending,
  input  irq_ctl_t        ctl,
  input  logic            iack,
  input  logic [2:0]      iack_lvl,
  output logic [NLVL-1:0] irq_lines,
  output logic            iack_valid,
  output logic [7:0]      iack_data
);

  logic acked;
  logic req_active;
  logic ack_accept;

  assign req_active = pending && ctl.en && (ctl.lvl != 3'd0) && !acked;
  assign ack_accept = iack && req_active && (iack_lvl == ctl.lvl);
  assign irq_lines  = req_active ? level_line(ctl.lvl) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acked      <= 1'b0;
      iack_valid <= 1'b0;
      iack_data  <= '0;
    end else begin
      iack_valid <= ack_accept;
      iack_data  <= ack_accept ? ctl.vec : 8'h00;
      if (ack_accept)    acked <= 1'b1;
      else if (!pending) acked <= 1'b0;
    end
  end

  AST_LINES_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_lines)); // R7
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_lines) |-> pending); // R7
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    iack_valid |=> !iack_valid); // R8
  AST_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n)
    iack_valid |-> (irq_lines == '0)); // R9

endmodule

// File: rtl/vec_interrupter.sv
module vec_interrupter
  import vi_pkg::*;
#(
  parameter int          NUM_CH  = 16,
  parameter logic [15:0] MOD_ID  = 16'h3803,
  parameter logic [3:0]  VERSION = 4'h2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [2:0]        en_set,
  input  logic [2:0]        en_clr,
  input  logic [NUM_CH-1:0] ovf_bits,
  input  logic              shd_strobe,
  input  logic              shd_clr,
  input  logic              tst_set,
  input  logic              tst_clr,
  input  logic              iack,
  input  logic [2:0]        iack_lvl,
  output logic              irq_flag,
  output logic [6:0]        irq_lines,
  output logic              iack_valid,
  output logic [7:0]        iack_data
);

  irq_ctl_t        ctl;
  logic [NSRC-1:0] cond;
  logic [NSRC-1:0] en;
  logic            pending;

  vi_id_reg #(.MOD_ID(MOD_ID), .VERSION(VERSION)) u_id (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
    .ctl(ctl), .rdata(reg_rdata)
  );

  vi_sources #(.NUM_CH(NUM_CH)) u_src (
    .clk(clk), .rst_n(rst_n), .en_set(en_set), .en_clr(en_clr),
    .ovf_bits(ovf_bits), .shd_strobe(shd_strobe), .shd_clr(shd_clr),
    .tst_set(tst_set), .tst_clr(tst_clr), .cond(cond), .en(en),
    .pending(pending)
  );

  vi_bus u_bus (
    .clk(clk), .rst_n(rst_n), .pending(pending), .ctl(ctl),
    .iack(iack), .iack_lvl(iack_lvl), .irq_lines(irq_lines),
    .iack_valid(iack_valid), .iack_data(iack_data)
  );

  assign irq_flag = pending;

  AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_flag |-> (|en)); // R6

endmodule

// File: tb/vec_interrupter_bench.sv
module vec_interrupter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2:0] en_set = '0, en_clr = '0;
  logic [NCH-1:0] ovf_bits = '0;
  logic shd_strobe = 1'b0, shd_clr = 1'b0, tst_set = 1'b0, tst_clr = 1'b0;
  logic iack = 1'b0;
  logic [2:0] iack_lvl = '0;
  logic irq_flag;
  logic [6:0] irq_lines;
  logic iack_valid;
  logic [7:0] iack_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // behavioural model state
  bit m_en[3];
  bit m_shd, m_tst, m_prev, m_acked, m_iv;
  int m_ctl, m_idata;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_interrupter #(.NUM_CH(NCH)) u_vec_interrupter (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .en_set(en_set), .en_clr(en_clr),
    .ovf_bits(ovf_bits), .shd_strobe(shd_strobe), .shd_clr(shd_clr),
    .tst_set(tst_set), .tst_clr(tst_clr), .iack(iack), .iack_lvl(iack_lvl),
    .irq_flag(irq_flag), .irq_lines(irq_lines), .iack_valid(iack_valid),
    .iack_data(iack_data)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic bit m_flag();
    bit c[3];
    c[0] = (ovf_bits != 0);
    c[1] = m_shd;
    c[2] = m_tst;
    return (c[0] && m_en[0]) || (c[1] && m_en[1]) || (c[2] && m_en[2]);
  endfunction

  function automatic int m_lvl();
    return (m_ctl >> 8) % 8;
  endfunction

  function automatic bit m_req();
    return m_flag() && ((m_ctl >> 11) % 2 == 1) && m_lvl() != 0 && !m_acked;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 3; k++) m_en[k] = 0;
    m_shd = 0; m_tst = 0; m_prev = 0; m_acked = 0; m_iv = 0;
    m_ctl = 0; m_idata = 0;
  endtask

  task automatic model_step();
    bit pend, req, accept;
    pend = m_flag();
    req = m_req();
    accept = iack && req && (int'(iack_lvl) == m_lvl());
    m_iv = accept;
    m_idata = accept ? (m_ctl % 256) : 0;
    if (accept) m_acked = 1;
    else if (!pend) m_acked = 0;
    for (int k = 0; k < 3; k++) begin
      if (en_set[k] && !en_clr[k]) m_en[k] = 1;
      else if (en_clr[k] && !en_set[k]) m_en[k] = 0;
    end
    if (shd_strobe && !m_prev) m_shd = 1;
    else if (shd_clr) m_shd = 0;
    m_prev = shd_strobe;
    if (tst_set) m_tst = 1;
    else if (tst_clr) m_tst = 0;
    if (reg_wr) m_ctl = int'(reg_wdata[11:0]);
  endtask

  task automatic compare_all();
    chk("R1 rdata", reg_rdata, {16'h3803, 4'h2, 12'(m_ctl)});
    chk("R6 irq_flag", irq_flag, m_flag());
    chk("R7 irq_lines", irq_lines, m_req() ? (1 << (m_lvl() - 1)) : 0);
    chk("R8 iack_valid", iack_valid, m_iv);
    chk("R8 iack_data", iack_data, m_idata);
  endtask

  task automatic tick();
    @(posedge clk);
    if (!rst_n) model_reset(); else model_step();
    @(negedge clk);
    compare_all();
    reg_wr = 0; en_set = 0; en_clr = 0; shd_clr = 0;
    tst_set = 0; tst_clr = 0; iack = 0;
  endtask

  task automatic wr_reg(input logic [31:0] d);
    reg_wr = 1; reg_wdata = d; tick();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R10: reset state at the ports
    chk("R10 rdata", reg_rdata, 32'h3803_2000);
    chk("R10 lines", irq_lines, 0);
    chk("R10 valid", iack_valid, 0);

    // R1: upper bits of a write ignored, level 5, vector B5, master off
    wr_reg(32'hFFFF_A5B5);
    chk("R1 write", reg_rdata, 32'h3803_25B5);

    // R5 and R2: test bit without enable gives no flag
    tst_set = 1; tick();
    chk("R2 no-enable flag", irq_flag, 0);
    en_set = 3'b100; tick();
    chk("R6 flag with master off", irq_flag, 1);
    chk("R7 lines with master off", irq_lines, 0);

    wr_reg(32'h0000_0DB5);
    chk("R7 level 5 line", irq_lines, 7'h10);

    // R8: acknowledge at another level ignored
    iack = 1; iack_lvl = 3; tick();
    chk("R8 wrong level", iack_valid, 0);
    chk("R8 wrong level lines", irq_lines, 7'h10);
    iack = 1; iack_lvl = 5; tick();
    chk("R8 vector", iack_data, 8'hB5);
    chk("R9 withdrawn", irq_lines, 0);
    tick();
    chk("R9 stays low", irq_lines, 0);

    // R9: rearm by disable, clear, enable
    en_clr = 3'b100; tick();
    chk("R2 clear", irq_flag, 0);
    tst_clr = 1; tick();
    en_set = 3'b100; tick();
    chk("R5 cleared", irq_flag, 0);
    tst_set = 1; tick();
    chk("R9 rearmed", irq_lines, 7'h10);

    // R2: set and clear together hold
    en_set = 3'b100; en_clr = 3'b100; tick();
    chk("R2 both hold", irq_flag, 1);
    tst_set = 1; tst_clr = 1; tick();
    chk("R5 set wins", irq_flag, 1);
    tst_clr = 1; tick();

    // R3: overflow OR
    en_set = 3'b001; tick();
    chk("R3 no ovf", irq_flag, 0);
    ovf_bits = 16'h0040; tick();
    chk("R3 ovf", irq_flag, 1);
    ovf_bits = 16'h8001; tick();
    ovf_bits = 16'h0000; tick();
    chk("R3 ovf gone", irq_flag, 0);

    // R4: shadow latch
    en_set = 3'b010; tick();
    shd_strobe = 1; repeat (3) tick();
    chk("R4 latched", irq_flag, 1);
    shd_strobe = 0; tick();
    chk("R4 held", irq_flag, 1);
    shd_clr = 1; tick();
    chk("R4 cleared", irq_flag, 0);
    shd_strobe = 1; shd_clr = 1; tick();
    chk("R4 edge wins", irq_flag, 1);
    shd_clr = 1; tick();
    chk("R4 no edge while high", irq_flag, 0);
    shd_strobe = 0; tick();

    // R7: level 0 and level 7
    tst_set = 1; tick();
    wr_reg(32'h0000_0833);
    chk("R7 level 0", irq_lines, 0);
    wr_reg(32'h0000_0F33);
    chk("R7 level 7", irq_lines, 7'h40);
    iack = 1; iack_lvl = 7; tick();
    chk("R8 vector 33", iack_data, 8'h33);
    repeat (4) tick();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule